// File: doc/BRIEF.md
# Clock Root Configuration Register Bank

This block is the register bank in front of a clock root generator. Software programs a source select, a half-integer divider value, a counter mode and the three M, N and D counter values into shadow registers. None of these writes reaches the generator on its own. Software then sets a commit bit in the command register. The bank snapshots the shadow contents at that moment and, after a fixed synchronisation delay, copies the snapshot into the active configuration that drives the divider and counter logic. The commit bit then clears itself, and a one-cycle done pulse tells the clocking logic that the handoff has finished.

The command register also carries a root enable bit, which drives an output directly. It has four per-register flags that show which shadow registers differ from the last committed set. A read-only flag reports that the root clock has stopped, based on a running indication from the clocking logic. Software polls the commit bit until it reads zero. The register port is a single-cycle write strobe with a combinational read of the addressed register.

Top module: `crc_root_regs`

## Requirements
- R1: Registers decode at byte offsets 0x00 (command), 0x04 (configuration), 0x08 (M), 0x0C (N) and 0x10 (D). Any other offset reads as zero, and a write to it changes nothing.
- R2: In the configuration register, the divider occupies bits HID_W-1:0, the source select occupies bits 10:8 and the counter mode occupies bits 13:12. A read returns the shadow value with every other bit zero.
- R3: A write to the configuration, M, N or D register changes only the shadow copy. The active outputs change only in the cycle in which the done pulse is high.
- R4: Writing 1 to command bit 0 starts a commit, and bit 0 reads 1 while the commit is pending. Exactly SYNC_CYCLES clock edges after the edge that accepted the write, the active outputs take the snapshot. At the same time cfg_done_o is high for one cycle and bit 0 reads 0 again.
- R5: The snapshot holds the shadow contents at the edge that accepted the commit. A shadow write made while the commit is pending is kept for a later commit.
- R6: While a commit is pending, writing 1 to bit 0 neither restarts nor extends it, and writing 0 to bit 0 does not cancel it.
- R7: Command bit 1 is root enable. Every command write loads it from wdata bit 1, and root_en_o follows it from the next cycle.
- R8: Command bits 4, 5, 6 and 7 are the dirty flags for the configuration, N, M and D registers. A flag sets on a write to its register. When a commit completes, the flags clear, except for registers written after that commit was accepted. Writes to these bits are ignored.
- R9: Command bit 31 reads 1 when root_on_i is low and 0 when it is high. Writes to it are ignored, and the other command bits read 0.
- R10: After reset, every shadow, active, dirty, enable and pending bit is zero.
- R11: M, N and D each keep only the low MND_W bits of a write. Higher bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the register at addr_i (combinational) |
| root_on_i | input | 1 | High while the root clock is running |
| clk_src_o | output | 3 | Active source select |
| clk_div_o | output | HID_W | Active divider value |
| clk_mode_o | output | 2 | Active counter mode |
| mnd_m_o | output | MND_W | Active M value |
| mnd_n_o | output | MND_W | Active N value |
| mnd_d_o | output | MND_W | Active D value |
| root_en_o | output | 1 | Root enable |
| cfg_done_o | output | 1 | One-cycle pulse when the commit handoff finishes |

## Verification
Each pattern targets one distinction the block must get right. Shadow writes with no commit show whether configuration leaks to the active outputs early. A shadow write that lands during a pending commit shows whether the snapshot is taken at acceptance or at completion, and whether that register stays dirty. A repeated commit request, and a zero written to the commit bit while a commit is pending, show that the completion cycle is fixed by the first accepted request. All-ones writes and writes to unmapped offsets expose field masks and decode holes. Toggling the running indication separates the read-only status bit from the writable enable bit.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_CMD = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_M   = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_N   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_D   = 5'h10;

    // command register bit positions
    localparam int B_UPD   = 0;
    localparam int B_EN    = 1;
    localparam int B_DIRTY = 4;   // four flags: cfg, N, M, D
    localparam int B_OFF   = 31;

    // configuration register fields
    localparam int SRC_LSB  = 8;
    localparam int SRC_W    = 3;
    localparam int MODE_LSB = 12;
    localparam int MODE_W   = 2;

    // dirty flag index per register
    localparam int DI_CFG = 0;
    localparam int DI_N   = 1;
    localparam int DI_M   = 2;
    localparam int DI_D   = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_CFG,
        SEL_M,
        SEL_N,
        SEL_D
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_CMD: return SEL_CMD;
            OFF_CFG: return SEL_CFG;
            OFF_M:   return SEL_M;
            OFF_N:   return SEL_N;
            OFF_D:   return SEL_D;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/crc_shadow_regs.sv
module crc_shadow_regs
    import crc_pkg::*;
#(
    parameter int HID_W = 5,
    parameter int MND_W = 8,
    localparam int CFG_W = HID_W + SRC_W + MODE_W + 3 * MND_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  reg_sel_e         sel_i,
    input  logic [31:0]      wdata_i,
    input  logic             accept_i,
    input  logic             load_i,
    input  logic             pending_i,
    output logic [CFG_W-1:0] shadow_o,
    output logic [3:0]       dirty_o
);

    typedef struct packed {
        logic [HID_W-1:0]  div;
        logic [SRC_W-1:0]  src;
        logic [MODE_W-1:0] mode;
        logic [MND_W-1:0]  m;
        logic [MND_W-1:0]  n;
        logic [MND_W-1:0]  d;
    } rcfg_t;

    typedef struct packed {
        rcfg_t      sh;
        logic [3:0] dirty;
        logic [3:0] late;   // written since the pending commit was accepted
    } state_t;

    state_t st_d, st_q;
    logic [3:0] set_w;
    logic unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d  = st_q;
        set_w = 4'b0000;
        if (wr_en_i) begin
            case (sel_i)
                SEL_CFG: begin
                    st_d.sh.div  = wdata_i[HID_W-1:0];
                    st_d.sh.src  = wdata_i[SRC_LSB +: SRC_W];
                    st_d.sh.mode = wdata_i[MODE_LSB +: MODE_W];
                    set_w[DI_CFG] = 1'b1;
                end
                SEL_N: begin
                    st_d.sh.n = wdata_i[MND_W-1:0];
                    set_w[DI_N] = 1'b1;
                end
                SEL_M: begin
                    st_d.sh.m = wdata_i[MND_W-1:0];
                    set_w[DI_M] = 1'b1;
                end
                SEL_D: begin
                    st_d.sh.d = wdata_i[MND_W-1:0];
                    set_w[DI_D] = 1'b1;
                end
                default: ;
            endcase
        end

        if (load_i) begin
            st_d.dirty = st_q.late | set_w;
            st_d.late  = 4'b0000;
        end else if (accept_i) begin
            st_d.dirty = st_q.dirty | set_w;
            st_d.late  = 4'b0000;
        end else begin
            st_d.dirty = st_q.dirty | set_w;
            if (pending_i) begin
                st_d.late = st_q.late | set_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_o = st_q.sh;
    assign dirty_o  = st_q.dirty;

endmodule

// File: rtl/crc_commit_ctrl.sv
module crc_commit_ctrl #(
    parameter int SYNC_CYCLES = 2,
    localparam int CNT_W = $clog2(SYNC_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic accept_o,
    output logic load_o,
    output logic pending_o,
    output logic done_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_CYCLES - 1);

    typedef struct packed {
        logic             pending;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } state_t;

    state_t st_d, st_q;

    assign accept_o = req_i && !st_q.pending;
    assign load_o   = st_q.pending && (st_q.cnt == LAST);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.pending) begin
            if (st_q.cnt == LAST) begin
                st_d.pending = 1'b0;
                st_d.cnt     = '0;
                st_d.done    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (req_i) begin
            st_d.pending = 1'b1;
            st_d.cnt     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = st_q.pending;
    assign done_o    = st_q.done;

endmodule

// File: rtl/crc_readback.sv
module crc_readback
    import crc_pkg::*;
#(
    parameter int HID_W = 5,
    parameter int MND_W = 8,
    localparam int CFG_W = HID_W + SRC_W + MODE_W + 3 * MND_W
) (
    input  reg_sel_e         sel_i,
    input  logic [CFG_W-1:0] shadow_i,
    input  logic [3:0]       dirty_i,
    input  logic             pending_i,
    input  logic             root_en_i,
    input  logic             root_on_i,
    output logic [31:0]      rdata_o
);

    typedef struct packed {
        logic [HID_W-1:0]  div;
        logic [SRC_W-1:0]  src;
        logic [MODE_W-1:0] mode;
        logic [MND_W-1:0]  m;
        logic [MND_W-1:0]  n;
        logic [MND_W-1:0]  d;
    } rcfg_t;

    rcfg_t sh;
    assign sh = shadow_i;

    always_comb begin
        rdata_o = '0;
        case (sel_i)
            SEL_CMD: begin
                rdata_o[B_UPD]          = pending_i;
                rdata_o[B_EN]           = root_en_i;
                rdata_o[B_DIRTY +: 4]   = dirty_i;
                rdata_o[B_OFF]          = !root_on_i;
            end
            SEL_CFG: begin
                rdata_o[HID_W-1:0]           = sh.div;
                rdata_o[SRC_LSB +: SRC_W]    = sh.src;
                rdata_o[MODE_LSB +: MODE_W]  = sh.mode;
            end
            SEL_M:   rdata_o[MND_W-1:0] = sh.m;
            SEL_N:   rdata_o[MND_W-1:0] = sh.n;
            SEL_D:   rdata_o[MND_W-1:0] = sh.d;
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/crc_root_regs.sv
module crc_root_regs
    import crc_pkg::*;
#(
    parameter int HID_W       = 5,
    parameter int MND_W       = 8,
    parameter int SYNC_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [4:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              root_on_i,
    output logic [2:0]        clk_src_o,
    output logic [HID_W-1:0]  clk_div_o,
    output logic [1:0]        clk_mode_o,
    output logic [MND_W-1:0]  mnd_m_o,
    output logic [MND_W-1:0]  mnd_n_o,
    output logic [MND_W-1:0]  mnd_d_o,
    output logic              root_en_o,
    output logic              cfg_done_o
);

    localparam int CFG_W = HID_W + SRC_W + MODE_W + 3 * MND_W;

    typedef struct packed {
        logic [HID_W-1:0]  div;
        logic [SRC_W-1:0]  src;
        logic [MODE_W-1:0] mode;
        logic [MND_W-1:0]  m;
        logic [MND_W-1:0]  n;
        logic [MND_W-1:0]  d;
    } rcfg_t;

    typedef struct packed {
        rcfg_t stage;
        rcfg_t active;
        logic  root_en;
    } state_t;

    state_t st_d, st_q;

    reg_sel_e         sel_w;
    logic             cmd_wr_w;
    logic             req_w;
    logic             accept_w;
    logic             load_w;
    logic             commit_pending;
    logic [CFG_W-1:0] shadow_w;
    logic [3:0]       dirty_w;

    assign sel_w    = decode_addr(addr_i);
    assign cmd_wr_w = wr_en_i && (sel_w == SEL_CMD);
    assign req_w    = cmd_wr_w && wdata_i[B_UPD];

    crc_commit_ctrl #(
        .SYNC_CYCLES (SYNC_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_w),
        .accept_o  (accept_w),
        .load_o    (load_w),
        .pending_o (commit_pending),
        .done_o    (cfg_done_o)
    );

    crc_shadow_regs #(
        .HID_W (HID_W),
        .MND_W (MND_W)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .sel_i     (sel_w),
        .wdata_i   (wdata_i),
        .accept_i  (accept_w),
        .load_i    (load_w),
        .pending_i (commit_pending),
        .shadow_o  (shadow_w),
        .dirty_o   (dirty_w)
    );

    crc_readback #(
        .HID_W (HID_W),
        .MND_W (MND_W)
    ) u_rd (
        .sel_i     (sel_w),
        .shadow_i  (shadow_w),
        .dirty_i   (dirty_w),
        .pending_i (commit_pending),
        .root_en_i (st_q.root_en),
        .root_on_i (root_on_i),
        .rdata_o   (rdata_o)
    );

    always_comb begin
        st_d = st_q;
        if (accept_w) begin
            st_d.stage = shadow_w;
        end
        if (load_w) begin
            st_d.active = st_q.stage;
        end
        if (cmd_wr_w) begin
            st_d.root_en = wdata_i[B_EN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_div_o  = st_q.active.div;
    assign clk_src_o  = st_q.active.src;
    assign clk_mode_o = st_q.active.mode;
    assign mnd_m_o    = st_q.active.m;
    assign mnd_n_o    = st_q.active.n;
    assign mnd_d_o    = st_q.active.d;
    assign root_en_o  = st_q.root_en;

endmodule

// File: rtl/crc_root_regs_chk.sv
module crc_root_regs_chk #(
    parameter int HID_W = 5,
    parameter int MND_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [4:0]       addr_i,
    input logic [31:0]      wdata_i,
    input logic             pending,
    input logic [2:0]       clk_src_o,
    input logic [HID_W-1:0] clk_div_o,
    input logic [1:0]       clk_mode_o,
    input logic [MND_W-1:0] mnd_m_o,
    input logic [MND_W-1:0] mnd_n_o,
    input logic [MND_W-1:0] mnd_d_o,
    input logic             root_en_o,
    input logic             cfg_done_o
);

    // R3
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done_o |-> $stable({clk_src_o, clk_div_o, clk_mode_o, mnd_m_o, mnd_n_o, mnd_d_o}));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done_o |=> !cfg_done_o);

    // R4
    done_after_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done_o |-> $past(pending));

    // R6
    pending_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> cfg_done_o);

    // R7
    root_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 5'h00) |=> (root_en_o == $past(wdata_i[1])));

endmodule

bind crc_root_regs crc_root_regs_chk #(
    .HID_W (HID_W),
    .MND_W (MND_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .pending    (commit_pending),
    .clk_src_o  (clk_src_o),
    .clk_div_o  (clk_div_o),
    .clk_mode_o (clk_mode_o),
    .mnd_m_o    (mnd_m_o),
    .mnd_n_o    (mnd_n_o),
    .mnd_d_o    (mnd_d_o),
    .root_en_o  (root_en_o),
    .cfg_done_o (cfg_done_o)
);

// File: tb/crc_root_regs_tb.sv
`timescale 1ns/1ps
module crc_root_regs_tb;

    localparam int HID_W = 5;
    localparam int MND_W = 8;
    localparam int SYNC  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        addr = 5'h00;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              root_on = 1'b1;
    logic [2:0]        src_o;
    logic [HID_W-1:0]  div_o;
    logic [1:0]        mode_o;
    logic [MND_W-1:0]  m_o, n_o, d_o;
    logic              en_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    crc_root_regs #(
        .HID_W (HID_W), .MND_W (MND_W), .SYNC_CYCLES (SYNC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en_i (wr_en), .addr_i (addr),
        .wdata_i (wdata), .rdata_o (rdata), .root_on_i (root_on),
        .clk_src_o (src_o), .clk_div_o (div_o), .clk_mode_o (mode_o),
        .mnd_m_o (m_o), .mnd_n_o (n_o), .mnd_d_o (d_o),
        .root_en_o (en_o), .cfg_done_o (done_o)
    );

    // reference model: index 0 div, 1 src, 2 mode, 3 m, 4 n, 5 d
    int sh[6]  = '{0, 0, 0, 0, 0, 0};
    int stg[6] = '{0, 0, 0, 0, 0, 0};
    int act[6] = '{0, 0, 0, 0, 0, 0};
    int m_dirty = 0, m_late = 0, m_pend = 0, m_cnt = 0, m_done = 0, m_en = 0;
    int setm;

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        case (a)
            5'h00: return 32'(m_pend) | 32'(m_en << 1) | 32'(m_dirty << 4) | (root_on ? 32'h0 : 32'h8000_0000);
            5'h04: return 32'(sh[0] | (sh[1] << 8) | (sh[2] << 12));
            5'h08: return 32'(sh[3]);
            5'h0C: return 32'(sh[4]);
            5'h10: return 32'(sh[5]);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            sh = '{0, 0, 0, 0, 0, 0}; stg = sh; act = sh;
            m_dirty = 0; m_late = 0; m_pend = 0; m_cnt = 0; m_done = 0; m_en = 0;
        end else begin
            setm = 0;
            if (wr_en) begin
                if (addr == 5'h04) setm = 1;
                if (addr == 5'h0C) setm = 2;
                if (addr == 5'h08) setm = 4;
                if (addr == 5'h10) setm = 8;
            end
            m_done = 0;
            if (m_pend != 0 && m_cnt == SYNC - 1) begin
                act = stg; m_pend = 0; m_cnt = 0; m_done = 1;
                m_dirty = m_late | setm; m_late = 0;
            end else if (m_pend != 0) begin
                m_cnt++; m_dirty |= setm; m_late |= setm;
            end else if (wr_en && addr == 5'h00 && wdata[0]) begin
                stg = sh; m_pend = 1; m_cnt = 0; m_late = 0;
            end else begin
                m_dirty |= setm;
            end
            if (wr_en && addr == 5'h00) m_en = int'(wdata[1]);
            if (wr_en) begin
                case (addr)
                    5'h04: begin
                        sh[0] = int'(wdata[HID_W-1:0]);
                        sh[1] = int'(wdata[10:8]);
                        sh[2] = int'(wdata[13:12]);
                    end
                    5'h08: sh[3] = int'(wdata[MND_W-1:0]);
                    5'h0C: sh[4] = int'(wdata[MND_W-1:0]);
                    5'h10: sh[5] = int'(wdata[MND_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expv);
        checks++;
        if (actual !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, actual, expv, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R4 div",  32'(div_o),  32'(act[0]));
            chk("R4 src",  32'(src_o),  32'(act[1]));
            chk("R4 mode", 32'(mode_o), 32'(act[2]));
            chk("R4 m",    32'(m_o),    32'(act[3]));
            chk("R4 n",    32'(n_o),    32'(act[4]));
            chk("R4 d",    32'(d_o),    32'(act[5]));
            chk("R4 done", 32'(done_o), 32'(m_done));
            chk("R7 en",   32'(en_o),   32'(m_en));
            chk("R1 rdata", rdata, exp_rd(addr));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); #0.5;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); #0.5;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] expv, input string req);
        @(negedge clk); #0.5;
        addr = a;
        #0.5;
        chk(req, rdata, expv);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.5 rst_n = 1'b1;

        // R10 reset state
        rd(5'h00, 32'h0, "R10");
        chk("R10", 32'({src_o, div_o, mode_o, m_o, n_o, d_o, en_o, done_o}), 32'h0);

        // R2 field layout and masking
        wr(5'h04, 32'h0000_2503);
        rd(5'h04, 32'h0000_2503, "R2");
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, 32'h0000_371F, "R2");
        wr(5'h04, 32'h0000_2503);

        // R11 MND masking
        wr(5'h08, 32'hFFFF_F1FF);
        rd(5'h08, 32'h0000_00FF, "R11");
        wr(5'h08, 32'h12);
        wr(5'h0C, 32'hED);
        wr(5'h10, 32'hDB);

        // R8 dirty flags, R3 no early effect
        rd(5'h00, 32'h0000_00F0, "R8");
        chk("R3", 32'({m_o, div_o}), 32'h0);

        // R4 commit timing and values
        wr(5'h00, 32'h3);
        rd(5'h00, 32'h0000_00F3, "R4");
        repeat (SYNC) @(negedge clk);
        chk("R4", 32'({div_o, src_o, mode_o}), 32'({5'd3, 3'd5, 2'd2}));
        chk("R4", 32'({m_o, n_o, d_o}), 32'h0012EDDB);
        rd(5'h00, 32'h2, "R8");

        // R5 write during pending goes to next commit
        wr(5'h00, 32'h3);
        wr(5'h08, 32'h55);
        repeat (SYNC + 1) @(negedge clk);
        chk("R5", 32'(m_o), 32'h12);
        rd(5'h00, 32'h42, "R8");
        rd(5'h08, 32'h55, "R5");

        // R6 repeated request does not extend the commit
        wr(5'h00, 32'h3);
        wr(5'h00, 32'h3);
        @(negedge clk); #0.5;
        chk("R6", 32'(done_o), 32'h0);
        @(negedge clk); #0.5;
        chk("R6", 32'(done_o), 32'h1);
        chk("R5", 32'(m_o), 32'h55);

        // R6 writing zero does not cancel; R7 enable cleared
        wr(5'h00, 32'h1);
        wr(5'h00, 32'h0);
        chk("R7", 32'(en_o), 32'h0);
        @(negedge clk); #0.5;
        @(negedge clk); #0.5;
        chk("R6", 32'(done_o), 32'h1);
        wr(5'h00, 32'h2);
        chk("R7", 32'(en_o), 32'h1);

        // R9 root-off flag, read-only
        root_on = 1'b0;
        rd(5'h00, 32'h8000_0002, "R9");
        wr(5'h00, 32'h7FFF_FF02);
        root_on = 1'b1;
        rd(5'h00, 32'h0000_0002, "R9");

        // R1 unmapped offsets
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, 32'h0, "R1");
        rd(5'h02, 32'h0, "R1");
        rd(5'h04, 32'h0000_2503, "R1");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule